// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

This block holds two independent 32-bit up-counters, a low half and a high half. Each half has its own period register, a 2-bit run-mode field and an interrupt output. Software programs the timer over a simple word-addressed register bus that has an address, a write strobe, write data and combinational read data. A single tick enable input stands in for the timer's input clock, so each half advances by at most one count per cycle in which the tick enable is high.

A global control word releases each half from reset and selects the counting arrangement. Only the dual unchained arrangement counts; every other arrangement code stops both halves. Each half can be disabled, run once, or run continuously. Software may rewrite a counter at any time, and may read it as a free-running time base.

The low half also has an absolute-compare register, present when the `HAS_CMP` parameter is set. When the low counter reaches the programmed value, a separate event output fires. Software loads the register with the current count plus a delta, and the sum wraps modulo 2^32.

Top module: `tmr_dual`

## Requirements
- R1: After reset, every register reads zero and all three interrupt outputs are low.
- R2: Register byte offsets are:
  - 0x10: low counter.
  - 0x14: high counter.
  - 0x18: low period.
  - 0x1C: high period.
  - 0x20: run-mode word. The low field is at bits 7:6 and the high field at bits 23:22. All other bits read 0.
  - 0x24: global word. Bits 1:0 release the low and high halves respectively; bits 3:2 hold the arrangement code. Other bits read 0.
  - Counters and periods keep all 32 bits.
- R3: A half advances only when all four of these hold:
  - its release bit is 1;
  - the arrangement code is 01 (dual unchained);
  - its run-mode field is 1 (one-shot) or 2 (continuous);
  - the tick enable is high.
  
  Field value 0 and field value 3 both stop the half. Arrangement codes 00, 10 and 11 stop both halves.
- R4: In continuous mode, a counting cycle that finds the counter equal to its period sets the counter to 0 at that edge and drives the half's interrupt high for the following cycle only.
- R5: In one-shot mode, a counting cycle that finds the counter equal to its period leaves the counter at the period value and clears the half's run-mode field to 0. The half's interrupt goes high for one cycle, and the counter does not advance afterwards.
- R6: A bus write to a counter takes priority over incrementing it in the same cycle. The counter can be read at any time.
- R7: While a half's release bit is 0, its counter is forced to 0 and bus writes to that counter have no effect.
- R8: The compare register sits at offset 0x28. `irq_cmp` is high for the cycle after a cycle in which the low half was counting and its counter equalled the compare value. Matches wrap modulo 2^32.
- R9: Reads of unmapped or unaligned offsets return 0. Writes to them change no register.
- R10: Writing 0 to the global word and then 0 to the run-mode word leaves both counters at 0 and stopped, and both words reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable; one count per high cycle |
| bus_addr | input | AW | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_lo | output | 1 | Low half period event |
| irq_hi | output | 1 | High half period event |
| irq_cmp | output | 1 | Low counter compare event |

## Verification
The properties assume the following about the inputs:
- `rst_n` is held low for at least one rising edge at start.
- Every input is a defined value at each rising edge.
- A write is qualified by `bus_we` in the cycle it is presented.

Only the register selected by the address is touched, so the event and wrap properties do not need to model bus traffic beyond "was this counter written this cycle". The bench changes every input on the falling edge. It holds `tick_en` low during all register setup, then raises it for an exact number of rising edges, which makes every expected count and interrupt cycle fixed.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    EM_OFF  = 2'd0,
    EM_ONCE = 2'd1,
    EM_LOOP = 2'd2,
    EM_RSVD = 2'd3
  } emode_e;

  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_RUN    = 8'h20;
  localparam logic [7:0] OFF_GLOB   = 8'h24;
  localparam logic [7:0] OFF_CMP    = 8'h28;

  localparam int unsigned SH_LO = 6;
  localparam int unsigned SH_HI = 22;
  localparam logic [1:0]  GM_DUAL = 2'b01;

  // mode field position for half idx
  function automatic int unsigned f_mode_shift(input int unsigned idx);
    return (idx == 0) ? SH_LO : SH_HI;
  endfunction

  function automatic logic [7:0] f_cnt_off(input int unsigned idx);
    return (idx == 0) ? OFF_CNT_LO : OFF_CNT_HI;
  endfunction

  function automatic logic [7:0] f_prd_off(input int unsigned idx);
    return (idx == 0) ? OFF_PRD_LO : OFF_PRD_HI;
  endfunction

  function automatic logic f_mode_counts(input emode_e m);
    return (m == EM_ONCE) || (m == EM_LOOP);
  endfunction
endpackage

// File: rtl/tmr_half.sv
`timescale 1ns/1ps
module tmr_half
  import tmr_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rel_i,
  input  logic         unchained_i,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] prd_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         done_o,
  output logic         irq_o
);
  function automatic logic [W-1:0] f_step(input logic [W-1:0] c);
    return c + {{(W-1){1'b0}}, 1'b1};
  endfunction

  emode_e       mode;
  logic [W-1:0] cnt_q;
  logic         irq_q;
  logic         run;
  logic         hit;

  assign mode   = emode_e'(mode_i);
  assign run    = rel_i && unchained_i && tick_i && f_mode_counts(mode);
  assign hit    = run && (cnt_q == prd_i);
  assign cnt_o  = cnt_q;
  assign run_o  = run;
  assign done_o = hit && (mode == EM_ONCE);
  assign irq_o  = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (!rel_i) begin
        cnt_q <= '0;
      end else if (cnt_we_i) begin
        cnt_q <= cnt_wdata_i;
      end else if (hit) begin
        if (mode == EM_LOOP) cnt_q <= '0;
      end else if (run) begin
        cnt_q <= f_step(cnt_q);
      end
    end
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_i |=> (cnt_q == '0)) else $error("hold"); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && !run && !cnt_we_i) |=> (cnt_q == $past(cnt_q))) else $error("idle"); // R3
  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode == EM_LOOP) && !cnt_we_i) |=> (cnt_q == '0)) else $error("wrap"); // R4
  AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && cnt_we_i) |=> (cnt_q == $past(cnt_wdata_i))) else $error("wr"); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(run) && ($past(cnt_q) == $past(prd_i)))) else $error("irq"); // R4
endmodule

// File: rtl/tmr_cmp.sv
`timescale 1ns/1ps
module tmr_cmp #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         run_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cmp_o,
  output logic         irq_o
);
  logic [W-1:0] cmp_q;
  logic         irq_q;
  logic         match;

  assign match = run_i && (cnt_i == cmp_q);
  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= match;
      if (we_i) cmp_q <= wdata_i;
    end
  end

  AST_CMP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(run_i) && ($past(cnt_i) == $past(cmp_q)))) else $error("cmp"); // R8
endmodule

// File: rtl/tmr_dual.sv
`timescale 1ns/1ps
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter bit          HAS_CMP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          irq_cmp
);
  localparam int unsigned NH = 2;

  logic [3:0]  glob_q;
  logic        unchained;
  logic        sel_run, sel_glob, sel_cmp;
  logic [31:0] cnt_w  [NH];
  logic [31:0] prd_w  [NH];
  logic [1:0]  mode_w [NH];
  logic        run_w  [NH];
  logic        done_w [NH];
  logic        irq_w  [NH];
  logic [31:0] cmp_w;

  assign unchained = (glob_q[3:2] == GM_DUAL);
  assign sel_run   = (bus_addr == AW'(OFF_RUN));
  assign sel_glob  = (bus_addr == AW'(OFF_GLOB));
  assign sel_cmp   = (bus_addr == AW'(OFF_CMP));

  always_ff @(posedge clk) begin
    if (!rst_n)                  glob_q <= '0;
    else if (bus_we && sel_glob) glob_q <= bus_wdata[3:0];
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    localparam int unsigned SH = f_mode_shift(i);
    logic        sel_cnt, sel_prd;
    logic [1:0]  mode_q;
    logic [31:0] prd_q;

    assign sel_cnt = (bus_addr == AW'(f_cnt_off(i)));
    assign sel_prd = (bus_addr == AW'(f_prd_off(i)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q <= 2'd0;
        prd_q  <= '0;
      end else begin
        if (bus_we && sel_run)     mode_q <= bus_wdata[SH +: 2];
        else if (done_w[i])        mode_q <= 2'd0;
        if (bus_we && sel_prd)     prd_q  <= bus_wdata;
      end
    end

    assign mode_w[i] = mode_q;
    assign prd_w[i]  = prd_q;

    tmr_half #(.W(32)) u_half (
      .clk         (clk),
      .rst_n       (rst_n),
      .rel_i       (glob_q[i]),
      .unchained_i (unchained),
      .tick_i      (tick_en),
      .mode_i      (mode_q),
      .prd_i       (prd_q),
      .cnt_we_i    (bus_we && sel_cnt),
      .cnt_wdata_i (bus_wdata),
      .cnt_o       (cnt_w[i]),
      .run_o       (run_w[i]),
      .done_o      (done_w[i]),
      .irq_o       (irq_w[i])
    );

    AST_ONCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_w[i] && !(bus_we && sel_run)) |=> (mode_q == 2'd0)) else $error("once"); // R5
  end

  if (HAS_CMP) begin : g_cmp
    tmr_cmp #(.W(32)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bus_we && sel_cmp),
      .wdata_i (bus_wdata),
      .run_i   (run_w[0]),
      .cnt_i   (cnt_w[0]),
      .cmp_o   (cmp_w),
      .irq_o   (irq_cmp)
    );
  end else begin : g_nocmp
    assign cmp_w   = '0;
    assign irq_cmp = 1'b0;
  end

  assign irq_lo = irq_w[0];
  assign irq_hi = irq_w[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFF_CNT_LO)) bus_rdata = cnt_w[0];
    if (bus_addr == AW'(OFF_CNT_HI)) bus_rdata = cnt_w[1];
    if (bus_addr == AW'(OFF_PRD_LO)) bus_rdata = prd_w[0];
    if (bus_addr == AW'(OFF_PRD_HI)) bus_rdata = prd_w[1];
    if (sel_run) begin
      bus_rdata[SH_LO +: 2] = mode_w[0];
      bus_rdata[SH_HI +: 2] = mode_w[1];
    end
    if (sel_glob) bus_rdata[3:0] = glob_q;
    if (sel_cmp)  bus_rdata = cmp_w;
  end

  AST_GLOB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_glob |-> (bus_rdata[31:4] == '0)) else $error("mask"); // R2
endmodule

// File: tb/tmr_dual_tb_top.sv
`timescale 1ns/1ps
module tmr_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi, irq_cmp;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tmr_dual #(.AW(8), .HAS_CMP(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 4'd2},
    '{1'b0, 8'h24, 32'h0000_000F, 4'd2},  // R2 global mask
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 4'd2},
    '{1'b0, 8'h20, 32'h00C0_00C0, 4'd2},  // R2 field positions
    '{1'b1, 8'h18, 32'hDEAD_BEEF, 4'd2},
    '{1'b0, 8'h18, 32'hDEAD_BEEF, 4'd2},
    '{1'b1, 8'h1C, 32'h1234_5678, 4'd2},
    '{1'b0, 8'h1C, 32'h1234_5678, 4'd2},
    '{1'b1, 8'h10, 32'hA5A5_A5A5, 4'd6},
    '{1'b0, 8'h10, 32'hA5A5_A5A5, 4'd6},  // R6 counter readable
    '{1'b1, 8'h14, 32'h0000_0042, 4'd6},
    '{1'b0, 8'h14, 32'h0000_0042, 4'd6},
    '{1'b1, 8'h28, 32'hCAFE_F00D, 4'd8},
    '{1'b0, 8'h28, 32'hCAFE_F00D, 4'd8},  // R8 compare offset
    '{1'b1, 8'h2C, 32'hFFFF_FFFF, 4'd9},
    '{1'b0, 8'h2C, 32'h0000_0000, 4'd9},  // R9 unmapped
    '{1'b0, 8'h00, 32'h0000_0000, 4'd9},
    '{1'b0, 8'h18, 32'hDEAD_BEEF, 4'd9},  // R9 no side effect
    '{1'b1, 8'h24, 32'h0000_0000, 4'd7},
    '{1'b0, 8'h10, 32'h0000_0000, 4'd7},  // R7 hold clears
    '{1'b0, 8'h14, 32'h0000_0000, 4'd7},
    '{1'b1, 8'h10, 32'h0000_0055, 4'd7},
    '{1'b0, 8'h10, 32'h0000_0000, 4'd7},  // R7 write ignored
    '{1'b1, 8'h20, 32'h0000_0000, 4'd2},
    '{1'b0, 8'h20, 32'h0000_0000, 4'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    #1;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    foreach (VEC[k]) begin
      rd(VEC[k].addr, v);
      check("R1", v, 32'h0);
    end
    check("R1 irqs", {29'h0, irq_lo, irq_hi, irq_cmp}, 32'h0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].we) wr(VEC[k].addr, VEC[k].data);
      else begin
        rd(VEC[k].addr, v);
        check($sformatf("R%0d vec%0d", VEC[k].req, k), v, VEC[k].data);
      end
    end

    // R4 continuous: period 3 -> match on 4th counting edge
    wr(8'h24, 32'h7);
    wr(8'h18, 32'd3);
    wr(8'h10, 32'd0);
    wr(8'h14, 32'd5);
    wr(8'h20, 32'h0000_0080);
    ticks(3);
    check("R4 no irq yet", {31'h0, irq_lo}, 32'h0);
    rd(8'h10, v); check("R4 count 3", v, 32'd3);
    rd(8'h14, v); check("R3 high idle field 0", v, 32'd5);
    ticks(1);
    check("R4 irq pulse", {31'h0, irq_lo}, 32'h1);
    rd(8'h10, v); check("R4 wrap to 0", v, 32'd0);
    check("R4 irq one cycle", {31'h0, irq_lo}, 32'h0);
    ticks(2);
    rd(8'h10, v); check("R4 keeps counting", v, 32'd2);

    // R5 one-shot on high half, period 2
    wr(8'h20, 32'h0040_0000);
    wr(8'h1C, 32'd2);
    wr(8'h14, 32'd0);
    ticks(3);
    check("R5 irq", {31'h0, irq_hi}, 32'h1);
    rd(8'h20, v); check("R5 field cleared", v, 32'h0);
    check("R5 irq one cycle", {31'h0, irq_hi}, 32'h0);
    rd(8'h14, v); check("R5 holds period", v, 32'd2);
    ticks(3);
    rd(8'h14, v); check("R5 stopped", v, 32'd2);
    check("R5 no re-fire", {31'h0, irq_hi}, 32'h0);

    // R6 write beats increment
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0000_0080);
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd100;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    rd(8'h10, v); check("R6 write wins", v, 32'd100);
    ticks(1);
    rd(8'h10, v); check("R6 then counts", v, 32'd101);

    // R3 reserved arrangement and reserved field
    wr(8'h24, 32'hB);
    wr(8'h10, 32'd7);
    ticks(4);
    rd(8'h10, v); check("R3 chained code stops", v, 32'd7);
    wr(8'h24, 32'h7);
    wr(8'h20, 32'h0000_00C0);
    ticks(4);
    rd(8'h10, v); check("R3 field 3 stops", v, 32'd7);

    // R7 low held, high released
    wr(8'h24, 32'h6);
    rd(8'h10, v); check("R7 held reads 0", v, 32'd0);
    wr(8'h10, 32'd9);
    rd(8'h10, v); check("R7 write ignored", v, 32'd0);

    // R8 compare with wrap: count FFFFFFFE, compare 1
    wr(8'h24, 32'h7);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h28, 32'hFFFF_FFFE + 32'd3);
    wr(8'h20, 32'h0000_0080);
    ticks(3);
    check("R8 not yet", {31'h0, irq_cmp}, 32'h0);
    ticks(1);
    check("R8 match after wrap", {31'h0, irq_cmp}, 32'h1);
    rd(8'h10, v); check("R8 count", v, 32'd2);

    // R10 shutdown order
    wr(8'h20, 32'h0040_0080);
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h0);
    ticks(3);
    rd(8'h24, v); check("R10 global 0", v, 32'h0);
    rd(8'h20, v); check("R10 run word 0", v, 32'h0);
    rd(8'h10, v); check("R10 low 0", v, 32'h0);
    rd(8'h14, v); check("R10 high 0", v, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule